// File: doc/BRIEF.md
# Program RAM Bootstrap Loader

This block fills a program RAM of 512 words of 24 bits when the processor comes up in bootstrap mode. On a start request it reads a selector word at external address $C000. Bit 23 of that word picks the source. When the bit is one, the loader walks a byte-wide external memory upward from $C000. When the bit is zero, it takes words that a host writes through three byte registers.

On the external path, every three consecutive bytes make one RAM word, with the low byte first, then the middle byte, then the high byte. On the host path, a host writes the high, middle and low byte registers. Writing the low byte commits the word to the next RAM address. A host flag ends host loading early. When loading finishes, the loader raises `done` and reports mode 2 (normal expanded). The core then starts fetching at $0000.

A start request can come from reset exit or from a mode-register write. For a mode-register write, the loader waits a short fixed delay before its first read, which covers a one-instruction slot.

Top module: `boot_loader`

## Requirements
- R1: After reset, `done` is 0, `mode` is 2'b01 (bootstrap), and `ext_rd` and `ram_we` are 0.
- R2: After `go`, the first external read is at address $C000. Read data is valid on `ext_rdata` in the cycle after `ext_rd`. If bit 23 of that data is 1, the external byte path is chosen. If it is 0, the host path is chosen.
- R3: On the external path, the bytes at $C000+3k, $C000+3k+1 and $C000+3k+2 (bits 7:0 of the read data) form RAM word k as low, middle and high byte. Words 0 to 511 are written, so reads never go past $C5FF. `ext_rd` is never high in two consecutive cycles.
- R4: On the host path, `host_sel` codes are 2 = high, 1 = middle, 0 = low, and 3 is ignored. Only a low write issues a RAM write. That write carries {latest high, latest middle, written low} and goes to the next address, counting from 0. High or middle writes alone cause no RAM write.
- R5: On the host path, `host_flag` high ends loading. No further words are written, and the address reached stays at the count of words loaded.
- R6: On the host path, loading ends by itself after the 512th word, even if `host_flag` stays low.
- R7: `done` rises in the cycle after the last RAM write, and `mode` is then 2'b10 (normal expanded). Both hold until the next `go`.
- R8: While `done` is high, no RAM write occurs, whatever the host drives.
- R9: A `go` with `go_sw` high (entry by mode-register write) delays the first external read by SW_DELAY cycles compared with `go` with `go_sw` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start request, accepted when idle or done |
| go_sw | input | 1 | Start came from a mode-register write (adds the delay) |
| ext_rd | output | 1 | External read strobe |
| ext_addr | output | 16 | External read address |
| ext_rdata | input | 24 | External read data, valid the cycle after `ext_rd` |
| host_wr | input | 1 | Host byte write strobe |
| host_sel | input | 2 | Host byte register select |
| host_wdata | input | 8 | Host byte data |
| host_flag | input | 1 | Host early-exit flag |
| ram_we | output | 1 | Program RAM write enable |
| ram_addr | output | 9 | Program RAM write address |
| ram_wdata | output | 24 | Program RAM write data |
| done | output | 1 | Loading finished; core may fetch from $0000 |
| mode | output | 2 | Operating mode: 01 bootstrap, 10 normal expanded |

## Verification
The bench builds the loader with its default values: 512 words, an external base of $C000 and a software entry delay of two cycles. These values bring two boundaries within reach of a full run: the external path reading up to $C5FF, and the host path closing on its 512th word. The short delay lets the bench count the extra cycles of a software entry exactly against a reset-style entry.

// File: rtl/boot_loader.sv
module boot_loader #(
  parameter int WORDS = 512,
  parameter int BW = 8,
  parameter int EAW = 16,
  parameter logic [EAW-1:0] EXT_BASE = 16'hC000,
  parameter int SW_DELAY = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  logic                     go_sw,
  output logic                     ext_rd,
  output logic [EAW-1:0]           ext_addr,
  input  logic [3*BW-1:0]          ext_rdata,
  input  logic                     host_wr,
  input  logic [1:0]               host_sel,
  input  logic [BW-1:0]            host_wdata,
  input  logic                     host_flag,
  output logic                     ram_we,
  output logic [$clog2(WORDS)-1:0] ram_addr,
  output logic [3*BW-1:0]          ram_wdata,
  output logic                     done,
  output logic [1:0]               mode
);
  localparam int DW  = 3 * BW;
  localparam int RAW = $clog2(WORDS);
  localparam int OFW = $clog2(3 * WORDS + 1);
  localparam int DCW = (SW_DELAY > 1) ? $clog2(SW_DELAY) : 1;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_SEL, S_CHK, S_EREQ, S_ECAP, S_HOST, S_DONE} st_t;

  st_t            st;
  logic [DCW-1:0] dcnt;
  logic [RAW-1:0] waddr;
  logic [OFW-1:0] eoff;
  logic [1:0]     ph;
  logic [BW-1:0]  b_lo, b_mid, b_hi;
  logic           last_word, ext_we, host_we;
  logic           unused_bits;

  assign unused_bits = ^ext_rdata[DW-2:BW];
  assign last_word   = (waddr == RAW'(WORDS - 1));
  assign ext_rd      = (st == S_SEL) || (st == S_EREQ);
  assign ext_addr    = EXT_BASE + EAW'(eoff);
  assign ext_we      = (st == S_ECAP) && (ph == 2'd2);
  assign host_we     = (st == S_HOST) && host_wr && (host_sel == 2'd0);
  assign ram_we      = ext_we || host_we;
  assign ram_addr    = waddr;
  assign ram_wdata   = (st == S_ECAP) ? {ext_rdata[BW-1:0], b_mid, b_lo}
                                      : {b_hi, b_mid, host_wdata};
  assign done        = (st == S_DONE);
  assign mode        = done ? 2'b10 : 2'b01;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      dcnt  <= '0;
      waddr <= '0;
      eoff  <= '0;
      ph    <= 2'd0;
      b_lo  <= '0;
      b_mid <= '0;
      b_hi  <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE:
          if (go) begin
            waddr <= '0;
            eoff  <= '0;
            ph    <= 2'd0;
            dcnt  <= '0;
            st    <= go_sw ? S_WAIT : S_SEL;
          end
        S_WAIT:
          if (dcnt == DCW'(SW_DELAY - 1)) st <= S_SEL;
          else dcnt <= dcnt + 1'b1;
        S_SEL: st <= S_CHK;
        S_CHK: st <= ext_rdata[DW-1] ? S_EREQ : S_HOST;
        S_EREQ: st <= S_ECAP;
        S_ECAP: begin
          eoff <= eoff + 1'b1;
          st   <= S_EREQ;
          case (ph)
            2'd0: begin b_lo <= ext_rdata[BW-1:0]; ph <= 2'd1; end
            2'd1: begin b_mid <= ext_rdata[BW-1:0]; ph <= 2'd2; end
            default: begin
              ph    <= 2'd0;
              waddr <= waddr + 1'b1;
              if (last_word) st <= S_DONE;
            end
          endcase
        end
        S_HOST: begin
          if (host_wr) begin
            case (host_sel)
              2'd2: b_hi <= host_wdata;
              2'd1: b_mid <= host_wdata;
              2'd0: begin
                waddr <= waddr + 1'b1;
                if (last_word) st <= S_DONE;
              end
              default: ;
            endcase
          end
          if (host_flag) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk #(
  parameter int WORDS = 512,
  parameter int EAW = 16,
  parameter logic [EAW-1:0] EXT_BASE = 16'hC000
) (
  input logic           clk,
  input logic           rst_n,
  input logic           go,
  input logic           ext_rd,
  input logic [EAW-1:0] ext_addr,
  input logic           host_wr,
  input logic [1:0]     host_sel,
  input logic           ram_we,
  input logic           done,
  input logic [1:0]     mode
);
  localparam logic [EAW-1:0] EXT_TOP = EXT_BASE + EAW'(3 * WORDS - 1);

  // R8
  no_write_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ram_we);

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go) |=> (done && mode == 2'b10));

  // R3
  ext_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rd |-> (ext_addr >= EXT_BASE && ext_addr <= EXT_TOP));

  // R3
  ext_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rd |=> !ext_rd);

  // R4
  write_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ($past(ext_rd) || (host_wr && host_sel == 2'd0)));
endmodule

bind boot_loader boot_loader_chk #(.WORDS(WORDS), .EAW(EAW), .EXT_BASE(EXT_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .ext_rd(ext_rd), .ext_addr(ext_addr),
  .host_wr(host_wr), .host_sel(host_sel), .ram_we(ram_we), .done(done), .mode(mode)
);

// File: tb/tb_boot_loader.sv
module tb_boot_loader;
  localparam int CLK_P = 10;
  localparam int WORDS = 512;
  localparam int SW_DELAY = 2;

  logic clk = 0, rst_n = 0, go = 0, go_sw = 0;
  logic ext_rd; logic [15:0] ext_addr; logic [23:0] ext_rdata = '0;
  logic host_wr = 0; logic [1:0] host_sel = 0; logic [7:0] host_wdata = 0; logic host_flag = 0;
  logic ram_we; logic [8:0] ram_addr; logic [23:0] ram_wdata;
  logic done; logic [1:0] mode;

  int checks = 0, fails = 0, cyc = 0;
  int wcnt = 0, late = 0, lastaddr = -1;
  logic [15:0] hiaddr = '0;
  logic selbit = 0;
  logic [7:0]  bmem [0:3*WORDS-1];
  logic [23:0] got  [0:WORDS-1];

  always #(CLK_P/2) clk = ~clk;

  boot_loader #(.WORDS(WORDS), .SW_DELAY(SW_DELAY)) dut (
    .clk(clk), .rst_n(rst_n), .go(go), .go_sw(go_sw),
    .ext_rd(ext_rd), .ext_addr(ext_addr), .ext_rdata(ext_rdata),
    .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata), .host_flag(host_flag),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .done(done), .mode(mode));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ext_rd) begin
      ext_rdata <= {(ext_addr == 16'hC000) ? selbit : 1'b0, 15'h0, bmem[ext_addr - 16'hC000]};
      if (ext_addr > hiaddr) hiaddr <= ext_addr;
    end
    if (ram_we) begin
      got[ram_addr] <= ram_wdata;
      wcnt <= wcnt + 1;
      lastaddr <= int'(ram_addr);
      if (done) late <= late + 1;
    end
  end

  function automatic logic [23:0] hword(int k);
    return {8'(k) ^ 8'h5A, 8'(k >> 1) + 8'h11, 8'(k * 3)};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; go = 0; host_wr = 0; host_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    wcnt = 0; late = 0; lastaddr = -1; hiaddr = '0;
    @(negedge clk);
  endtask

  task automatic pulse_go(input logic sw);
    @(negedge clk); go = 1; go_sw = sw;
    @(negedge clk); go = 0;
  endtask

  task automatic hwr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_sel = s; host_wdata = d;
  endtask

  task automatic hidle();
    @(negedge clk); host_wr = 0;
  endtask

  task automatic wait_done(input int lim);
    for (int i = 0; i < lim && !done; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(done == 0, "R1 done", done, 0);
    chk(mode == 2'b01, "R1 mode", mode, 1);
    chk(ext_rd == 0, "R1 ext_rd", ext_rd, 0);
    chk(ram_we == 0, "R1 ram_we", ram_we, 0);
  endtask

  task automatic t_ext();
    int bad = 0;
    do_reset();
    selbit = 1;
    for (int i = 0; i < 3*WORDS; i++) bmem[i] = 8'((i * 7 + 3) ^ (i >> 3));
    pulse_go(0);
    wait_done(8000);
    chk(done == 1, "R7 ext done", done, 1);
    chk(mode == 2'b10, "R7 ext mode", mode, 2);
    chk(wcnt == WORDS, "R3 ext word count", wcnt, WORDS);
    chk(hiaddr == 16'hC5FF, "R3 ext top address", hiaddr, 16'hC5FF);
    for (int k = 0; k < WORDS; k++)
      if (got[k] !== {bmem[3*k+2], bmem[3*k+1], bmem[3*k]}) begin
        bad++;
        if (bad < 4) chk(0, "R3 ext word", got[k], {bmem[3*k+2], bmem[3*k+1], bmem[3*k]});
      end
    chk(bad == 0, "R2 R3 ext all words", bad, 0);
    repeat (20) @(negedge clk);
    chk(late == 0, "R8 ext late writes", late, 0);
    chk(done == 1, "R7 ext hold", done, 1);
  endtask

  task automatic t_host_full();
    int bad = 0;
    do_reset();
    selbit = 0;
    bmem[0] = 8'hFF;
    pulse_go(0);
    repeat (3) @(negedge clk);
    for (int k = 0; k < WORDS; k++) begin
      logic [23:0] w = hword(k);
      hwr(2'd2, w[23:16]); hwr(2'd1, w[15:8]); hwr(2'd0, w[7:0]);
    end
    hidle();
    chk(done == 1, "R6 host auto end", done, 1);
    chk(wcnt == WORDS, "R6 host word count", wcnt, WORDS);
    for (int k = 0; k < WORDS; k++)
      if (got[k] !== hword(k)) begin
        bad++;
        if (bad < 4) chk(0, "R4 host word", got[k], hword(k));
      end
    chk(bad == 0, "R2 R4 host all words", bad, 0);
    hwr(2'd2, 8'h01); hwr(2'd1, 8'h02); hwr(2'd0, 8'h03); hidle();
    chk(wcnt == WORDS, "R8 host writes after done", wcnt, WORDS);
    chk(late == 0, "R8 host late", late, 0);
  endtask

  task automatic t_host_early();
    do_reset();
    selbit = 0;
    pulse_go(0);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      logic [23:0] w = hword(k + 100);
      hwr(2'd2, w[23:16]); hwr(2'd1, w[15:8]); hwr(2'd0, w[7:0]);
    end
    hidle();
    chk(done == 0, "R5 not done before flag", done, 0);
    @(negedge clk); host_flag = 1;
    @(negedge clk); host_flag = 0;
    chk(done == 1, "R5 flag exit", done, 1);
    chk(mode == 2'b10, "R7 flag mode", mode, 2);
    chk(wcnt == 10, "R5 words at exit", wcnt, 10);
    chk(lastaddr == 9, "R5 address reached", lastaddr, 9);
    chk(got[9] === hword(109), "R4 last early word", got[9], hword(109));
    hwr(2'd2, 8'hAA); hwr(2'd0, 8'hBB); hidle();
    chk(wcnt == 10 && late == 0, "R8 ignored after exit", wcnt, 10);
  endtask

  task automatic t_host_regs();
    do_reset();
    selbit = 0;
    pulse_go(0);
    repeat (3) @(negedge clk);
    hwr(2'd2, 8'h11); hwr(2'd1, 8'h22); hwr(2'd2, 8'h33); hwr(2'd3, 8'h44); hidle();
    chk(wcnt == 0, "R4 no write on high/mid", wcnt, 0);
    hwr(2'd0, 8'h55); hidle();
    chk(wcnt == 1, "R4 low commits", wcnt, 1);
    chk(got[0] === 24'h332255, "R4 latest bytes", got[0], 24'h332255);
    hwr(2'd1, 8'h66); hwr(2'd0, 8'h77); hidle();
    chk(got[1] === 24'h336677, "R4 kept high byte", got[1], 24'h336677);
    @(negedge clk); host_flag = 1; @(negedge clk); host_flag = 0;
    chk(done == 1, "R5 regs exit", done, 1);
  endtask

  task automatic t_delay();
    int n0 = 0, n1 = 0;
    do_reset();
    selbit = 0;
    @(negedge clk); go = 1; go_sw = 0;
    do begin @(negedge clk); go = 0; n0++; end while (!ext_rd && n0 < 20);
    chk(ext_addr == 16'hC000, "R2 first read address", ext_addr, 16'hC000);
    do_reset();
    @(negedge clk); go = 1; go_sw = 1;
    do begin @(negedge clk); go = 0; n1++; end while (!ext_rd && n1 < 20);
    chk(n0 == 1, "R9 reset entry latency", n0, 1);
    chk(n1 - n0 == SW_DELAY, "R9 software entry delay", n1 - n0, SW_DELAY);
    go_sw = 0;
  endtask

  initial begin
    t_reset();
    t_ext();
    t_host_full();
    t_host_early();
    t_host_regs();
    t_delay();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule